// File: doc/BRIEF.md
# Parameter Set Reload and Completion Signalling Unit

This unit sits beside the parameter RAM of a multi-channel DMA engine. That RAM holds one eight-word set per channel, plus extra sets that are used only as reload images. Each time the channel logic issues a transfer request, it passes in the channel number and the current option word, count words and link word. The unit then does one of three things. It writes the decremented counts back, or it copies a whole linked set over the exhausted one, or it leaves the RAM alone when the set is marked fixed.

The unit also turns request events into completion signals. Each request is either intermediate (more requests follow) or final (the set is exhausted). In early mode the signal comes from the issue strobe. In normal mode it comes from the completion strobe returned by the transfer engine. Separate option bits decide whether each kind raises a sticky interrupt-pending bit or a one-cycle chain trigger. The completion code in the option word picks which bit or which channel.

Set words, by index: 0 options, 1 source, 2 counts `{bcnt[31:16], acnt[15:0]}`, 3 destination, 4 array strides, 5 `{bcntReload[31:16], link[15:0]}`, 6 frame strides, 7 `{16'h0, ccnt[15:0]}`. Channel n owns set n. The RAM word address is `{set, wordIndex}`. Option bits: 0 fixed set, 2 frame-per-request mode (0 = one array per request), 11 early signalling, 17:12 completion code, 20 final interrupt enable, 21 intermediate interrupt enable, 22 final chain enable, 23 intermediate chain enable.

Top module: `plc_unit`

## Requirements
- R1: A request whose option bit 0 is set causes no RAM write and leaves busy low, while its completion signalling still takes place.
- R2: In array-per-request mode, an intermediate request writes word 2 with bcnt-1 when bcnt>1. Otherwise it writes bcnt = bcntReload and ccnt-1. Word 2 is written in the first cycle after the issue edge and word 7 in the second cycle, with acnt preserved.
- R3: In frame-per-request mode every request decrements ccnt and keeps bcnt. A request is final when ccnt is 1 in this mode, and when bcnt and ccnt are both 1 in array-per-request mode.
- R4: When a final request hits a non-fixed set whose link is not 16'hFFFF, the eight words of the set with index link are copied into the channel's set, word 0 first.
- R5: A final request on a non-fixed set whose link is 16'hFFFF overwrites the set with zeros, except word 5, which becomes 32'h0000FFFF. Any later request on that channel is then rejected as an error.
- R6: With bit 20 set, a final request sets intPending[code] and an intermediate one does not.
- R7: With bit 21 set, an intermediate request sets intPending[code] and a final one does not.
- R8: Bits 22 and 23 pulse chainTrig[code] for exactly one cycle, for final and intermediate requests respectively.
- R9: In early mode, signalling happens in the cycle after the accepted issue and the completion strobe has no effect. In normal mode, the issue raises nothing and the completion strobe, with its final flag, raises the signal one cycle later.
- R10: intPending bits stay set until a write-one-to-clear. A set and a clear of the same bit in the same cycle leave it set, and other bits are unaffected.
- R11: An issue while busy is high is ignored and pulses errPulse in the next cycle.
- R12: An issue with acnt, bcnt or ccnt equal to zero is ignored and pulses errPulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issValid | input | 1 | Request issued strobe |
| issChan | input | CH_W | Channel of the issued request |
| issOpt | input | 32 | Option word of the set |
| issCntWord | input | 32 | Word 2 of the set |
| issLinkWord | input | 32 | Word 5 of the set |
| issCcntWord | input | 32 | Word 7 of the set |
| cmplValid | input | 1 | Request completed strobe from the transfer engine |
| cmplOpt | input | 32 | Option word carried with the completed request |
| cmplFinal | input | 1 | Completed request was the last of its set |
| intClrValid | input | 1 | Pending clear strobe |
| intClrMask | input | NUM_CHAN | Bits to clear (write one to clear) |
| ramRdData | input | 32 | Read data, one cycle after ramRdEn |
| ramWrEn | output | 1 | RAM write enable |
| ramWrAddr | output | SET_W+3 | RAM write word address |
| ramWrData | output | 32 | RAM write data |
| ramRdEn | output | 1 | RAM read enable |
| ramRdAddr | output | SET_W+3 | RAM read word address |
| intPending | output | NUM_CHAN | Sticky interrupt-pending bits by completion code |
| chainTrig | output | NUM_CHAN | One-cycle chain trigger per target channel |
| busy | output | 1 | Write-back or reload in progress |
| errPulse | output | 1 | One-cycle pulse for a rejected request |

## Verification
Two signalling sources can act in the same cycle. The first is an early-mode issue that sets a pending bit and pulses a chain. The second is a normal-mode completion strobe for another code that does the same. The bench drives both on one edge, together with a clear aimed at the bit the issue is setting. It then expects both pending bits set, the cleared bit still held, and two chain bits high in the same pulse. A second collision drives a repeat issue into the first cycle of a write-back. The bench judges it by the error pulse and by the RAM count, which must show exactly one decrement.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int OPT_FIXED     = 0;
  localparam int OPT_FRAME     = 2;
  localparam int OPT_EARLY     = 11;
  localparam int OPT_CODE_LSB  = 12;
  localparam int CODE_BITS     = 6;
  localparam int OPT_FIN_INT   = 20;
  localparam int OPT_MID_INT   = 21;
  localparam int OPT_FIN_CHAIN = 22;
  localparam int OPT_MID_CHAIN = 23;

  localparam logic [2:0] WD_CNT  = 3'd2;
  localparam logic [2:0] WD_LINK = 3'd5;
  localparam logic [2:0] WD_CCNT = 3'd7;
  localparam logic [15:0] LINK_NONE = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UPD_CNT, ST_UPD_CCNT, ST_COPY, ST_ZERO
  } plcState_t;

  typedef struct packed {
    logic                 intSet;
    logic                 chainSet;
    logic [CODE_BITS-1:0] code;
  } plcSig_t;

  typedef struct packed {
    logic        wrEn;
    logic [7:0]  wrSet;
    logic [2:0]  wrIdx;
    logic        wrFromRead;
    logic [31:0] wrData;
    logic        rdEn;
    logic [7:0]  rdSet;
    logic [2:0]  rdIdx;
    plcSig_t     issSig;
    plcSig_t     cmpSig;
  } plcStrobe_t;
endpackage

// File: rtl/plc_ctrl.sv
module plc_ctrl
  import plc_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_CHAN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issValid,
  input  logic [CH_W-1:0]     issChan,
  input  logic [31:0]         issOpt,
  input  logic [31:0]         issCntWord,
  input  logic [31:0]         issLinkWord,
  input  logic [31:0]         issCcntWord,
  input  logic                cmplValid,
  input  logic [31:0]         cmplOpt,
  input  logic                cmplFinal,
  output plcStrobe_t          strb,
  output logic                busy,
  output logic                errPulse
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int CH_W  = $clog2(NUM_CHAN);

  plcState_t         state;
  logic [CH_W-1:0]   chanR;
  logic [SET_W-1:0]  linkSetR;
  logic [31:0]       newCntR;
  logic [31:0]       newCcntR;
  logic [3:0]        idxR;
  logic              errR;

  logic [15:0] acnt, bcnt, ccnt, bcntRld, link;
  logic        isFixed, isFrame, isEarly, zeroCnt, isLast, accept;
  logic [15:0] nextB, nextC;

  always_comb begin
    acnt    = issCntWord[15:0];
    bcnt    = issCntWord[31:16];
    ccnt    = issCcntWord[15:0];
    link    = issLinkWord[15:0];
    bcntRld = issLinkWord[31:16];
    isFixed = issOpt[OPT_FIXED];
    isFrame = issOpt[OPT_FRAME];
    isEarly = issOpt[OPT_EARLY];
    zeroCnt = (acnt == 16'd0) || (bcnt == 16'd0) || (ccnt == 16'd0);
    isLast  = isFrame ? (ccnt == 16'd1) : ((bcnt == 16'd1) && (ccnt == 16'd1));
    accept  = issValid && (state == ST_IDLE) && !zeroCnt;
    if (isFrame) begin
      nextB = bcnt;
      nextC = ccnt - 16'd1;
    end else if (bcnt > 16'd1) begin
      nextB = bcnt - 16'd1;
      nextC = ccnt;
    end else begin
      nextB = bcntRld;
      nextC = ccnt - 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      chanR    <= '0;
      linkSetR <= '0;
      newCntR  <= '0;
      newCcntR <= '0;
      idxR     <= '0;
      errR     <= 1'b0;
    end else begin
      errR <= issValid && ((state != ST_IDLE) || zeroCnt);
      unique case (state)
        ST_IDLE: begin
          if (accept && !isFixed) begin
            chanR <= issChan;
            idxR  <= '0;
            if (!isLast) begin
              newCntR  <= {nextB, acnt};
              newCcntR <= {16'h0, nextC};
              state    <= ST_UPD_CNT;
            end else if (link == LINK_NONE) begin
              state <= ST_ZERO;
            end else begin
              linkSetR <= link[SET_W-1:0];
              state    <= ST_COPY;
            end
          end
        end
        ST_UPD_CNT:  state <= ST_UPD_CCNT;
        ST_UPD_CCNT: state <= ST_IDLE;
        ST_COPY: begin
          if (idxR == 4'd8) state <= ST_IDLE;
          else idxR <= idxR + 4'd1;
        end
        ST_ZERO: begin
          if (idxR == 4'd7) state <= ST_IDLE;
          else idxR <= idxR + 4'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    unique case (state)
      ST_UPD_CNT: begin
        strb.wrEn   = 1'b1;
        strb.wrSet  = 8'(chanR);
        strb.wrIdx  = WD_CNT;
        strb.wrData = newCntR;
      end
      ST_UPD_CCNT: begin
        strb.wrEn   = 1'b1;
        strb.wrSet  = 8'(chanR);
        strb.wrIdx  = WD_CCNT;
        strb.wrData = newCcntR;
      end
      ST_COPY: begin
        strb.rdEn       = (idxR != 4'd8);
        strb.rdSet      = 8'(linkSetR);
        strb.rdIdx      = idxR[2:0];
        strb.wrEn       = (idxR != 4'd0);
        strb.wrSet      = 8'(chanR);
        strb.wrIdx      = 3'(idxR - 4'd1);
        strb.wrFromRead = 1'b1;
      end
      ST_ZERO: begin
        strb.wrEn   = 1'b1;
        strb.wrSet  = 8'(chanR);
        strb.wrIdx  = idxR[2:0];
        strb.wrData = (idxR[2:0] == WD_LINK) ? {16'h0, LINK_NONE} : 32'h0;
      end
      default: ;
    endcase
    // issue-side signalling, early mode only
    strb.issSig.code     = issOpt[OPT_CODE_LSB +: CODE_BITS];
    strb.issSig.intSet   = accept && isEarly &&
                           (isLast ? issOpt[OPT_FIN_INT] : issOpt[OPT_MID_INT]);
    strb.issSig.chainSet = accept && isEarly &&
                           (isLast ? issOpt[OPT_FIN_CHAIN] : issOpt[OPT_MID_CHAIN]);
    // completion-side signalling, normal mode only
    strb.cmpSig.code     = cmplOpt[OPT_CODE_LSB +: CODE_BITS];
    strb.cmpSig.intSet   = cmplValid && !cmplOpt[OPT_EARLY] &&
                           (cmplFinal ? cmplOpt[OPT_FIN_INT] : cmplOpt[OPT_MID_INT]);
    strb.cmpSig.chainSet = cmplValid && !cmplOpt[OPT_EARLY] &&
                           (cmplFinal ? cmplOpt[OPT_FIN_CHAIN] : cmplOpt[OPT_MID_CHAIN]);
  end

  assign busy     = (state != ST_IDLE);
  assign errPulse = errR;

  logic unusedBits;
  assign unusedBits = ^{issOpt, issCcntWord[31:16], cmplOpt};
endmodule

// File: rtl/plc_datapath.sv
module plc_datapath
  import plc_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_CHAN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  plcStrobe_t          strb,
  input  logic [31:0]         ramRdData,
  input  logic                intClrValid,
  input  logic [NUM_CHAN-1:0] intClrMask,
  output logic                ramWrEn,
  output logic [ADDR_W-1:0]   ramWrAddr,
  output logic [31:0]         ramWrData,
  output logic                ramRdEn,
  output logic [ADDR_W-1:0]   ramRdAddr,
  output logic [NUM_CHAN-1:0] intPending,
  output logic [NUM_CHAN-1:0] chainTrig
);
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int ADDR_W = SET_W + 3;

  assign ramWrEn   = strb.wrEn;
  assign ramWrAddr = {strb.wrSet[SET_W-1:0], strb.wrIdx};
  assign ramWrData = strb.wrFromRead ? ramRdData : strb.wrData;
  assign ramRdEn   = strb.rdEn;
  assign ramRdAddr = {strb.rdSet[SET_W-1:0], strb.rdIdx};

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gCode
    logic setInt, setChain, clrBit;
    always_comb begin
      setInt   = (strb.issSig.intSet   && (strb.issSig.code == CODE_BITS'(g))) ||
                 (strb.cmpSig.intSet   && (strb.cmpSig.code == CODE_BITS'(g)));
      setChain = (strb.issSig.chainSet && (strb.issSig.code == CODE_BITS'(g))) ||
                 (strb.cmpSig.chainSet && (strb.cmpSig.code == CODE_BITS'(g)));
      clrBit   = intClrValid && intClrMask[g];
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        intPending[g] <= 1'b0;
        chainTrig[g]  <= 1'b0;
      end else begin
        intPending[g] <= setInt || (intPending[g] && !clrBit);
        chainTrig[g]  <= setChain;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{strb.wrSet, strb.rdSet};
endmodule

// File: rtl/plc_unit.sv
module plc_unit
  import plc_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_CHAN = 8,
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int CH_W   = $clog2(NUM_CHAN),
  localparam int ADDR_W = SET_W + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issValid,
  input  logic [CH_W-1:0]     issChan,
  input  logic [31:0]         issOpt,
  input  logic [31:0]         issCntWord,
  input  logic [31:0]         issLinkWord,
  input  logic [31:0]         issCcntWord,
  input  logic                cmplValid,
  input  logic [31:0]         cmplOpt,
  input  logic                cmplFinal,
  input  logic                intClrValid,
  input  logic [NUM_CHAN-1:0] intClrMask,
  input  logic [31:0]         ramRdData,
  output logic                ramWrEn,
  output logic [ADDR_W-1:0]   ramWrAddr,
  output logic [31:0]         ramWrData,
  output logic                ramRdEn,
  output logic [ADDR_W-1:0]   ramRdAddr,
  output logic [NUM_CHAN-1:0] intPending,
  output logic [NUM_CHAN-1:0] chainTrig,
  output logic                busy,
  output logic                errPulse
);
  plcStrobe_t strb;

  plc_ctrl #(.NUM_SETS(NUM_SETS), .NUM_CHAN(NUM_CHAN)) uCtrl (
    .clk(clk), .rstN(rstN),
    .issValid(issValid), .issChan(issChan), .issOpt(issOpt),
    .issCntWord(issCntWord), .issLinkWord(issLinkWord), .issCcntWord(issCcntWord),
    .cmplValid(cmplValid), .cmplOpt(cmplOpt), .cmplFinal(cmplFinal),
    .strb(strb), .busy(busy), .errPulse(errPulse)
  );

  plc_datapath #(.NUM_SETS(NUM_SETS), .NUM_CHAN(NUM_CHAN)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .ramRdData(ramRdData),
    .intClrValid(intClrValid), .intClrMask(intClrMask),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr),
    .intPending(intPending), .chainTrig(chainTrig)
  );
endmodule

// File: rtl/plc_checker.sv
module plc_checker
  import plc_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                issValid,
  input logic [31:0]         issOpt,
  input logic [31:0]         issCntWord,
  input logic                cmplValid,
  input logic [31:0]         cmplOpt,
  input logic                intClrValid,
  input logic [NUM_CHAN-1:0] intClrMask,
  input logic                ramRdEn,
  input logic [NUM_CHAN-1:0] intPending,
  input logic [NUM_CHAN-1:0] chainTrig,
  input logic                busy,
  input logic                errPulse
);
  assert_fixed_no_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !busy && issOpt[OPT_FIXED]) |=> !busy);

  assert_reload_read_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEn |-> busy);

  assert_chain_sources_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chainTrig) <= 2);

  assert_early_cmpl_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && cmplOpt[OPT_EARLY] && !issValid) |=> (chainTrig == '0));

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gSticky
    assert_pending_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
      (intPending[g] && !(intClrValid && intClrMask[g])) |=> intPending[g]);
  end

  assert_busy_reject_R11: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && busy) |=> errPulse);

  assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && (issCntWord[15:0] == 16'd0)) |=> errPulse);
endmodule

bind plc_unit plc_checker #(.NUM_CHAN(NUM_CHAN)) uChk (
  .clk(clk), .rstN(rstN), .issValid(issValid), .issOpt(issOpt),
  .issCntWord(issCntWord), .cmplValid(cmplValid), .cmplOpt(cmplOpt),
  .intClrValid(intClrValid), .intClrMask(intClrMask), .ramRdEn(ramRdEn),
  .intPending(intPending), .chainTrig(chainTrig), .busy(busy), .errPulse(errPulse)
);

// File: tb/sim_plc_unit.sv
`timescale 1ns/1ps
module sim_plc_unit;
  localparam int NUM_SETS = 16;
  localparam int NUM_CHAN = 8;
  localparam int CH_W = 3;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issValid = 1'b0;
  logic [CH_W-1:0] issChan = '0;
  logic [31:0] issOpt = '0, issCntWord = '0, issLinkWord = '0, issCcntWord = '0;
  logic cmplValid = 1'b0;
  logic [31:0] cmplOpt = '0;
  logic cmplFinal = 1'b0;
  logic intClrValid = 1'b0;
  logic [NUM_CHAN-1:0] intClrMask = '0;
  logic [31:0] ramRdData;
  logic ramWrEn, ramRdEn, busy, errPulse;
  logic [ADDR_W-1:0] ramWrAddr, ramRdAddr;
  logic [31:0] ramWrData;
  logic [NUM_CHAN-1:0] intPending, chainTrig;

  logic [31:0] mem [NUM_SETS*8];
  logic hostWe = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [31:0] hostData = '0;
  int wrCount = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  plc_unit #(.NUM_SETS(NUM_SETS), .NUM_CHAN(NUM_CHAN)) u0 (
    .clk(clk), .rstN(rstN), .issValid(issValid), .issChan(issChan), .issOpt(issOpt),
    .issCntWord(issCntWord), .issLinkWord(issLinkWord), .issCcntWord(issCcntWord),
    .cmplValid(cmplValid), .cmplOpt(cmplOpt), .cmplFinal(cmplFinal),
    .intClrValid(intClrValid), .intClrMask(intClrMask), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr), .intPending(intPending),
    .chainTrig(chainTrig), .busy(busy), .errPulse(errPulse)
  );

  always @(posedge clk) begin
    if (hostWe) mem[hostAddr] <= hostData;
    else if (ramWrEn) begin
      mem[ramWrAddr] <= ramWrData;
      wrCount <= wrCount + 1;
    end
    if (ramRdEn) ramRdData <= mem[ramRdAddr];
  end

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkOpt(input bit fixd, input bit frame, input bit early,
      input int code, input bit fi, input bit mi, input bit fc, input bit mc);
    logic [31:0] o;
    o = '0;
    o[0] = fixd; o[2] = frame; o[11] = early; o[17:12] = 6'(code);
    o[20] = fi; o[21] = mi; o[22] = fc; o[23] = mc;
    return o;
  endfunction

  task automatic progWord(input int addr, input logic [31:0] data);
    hostWe = 1'b1; hostAddr = ADDR_W'(addr); hostData = data;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic progSet(input int s, input logic [31:0] opt, input logic [31:0] cnt,
      input logic [31:0] lnk, input logic [31:0] cc);
    for (int k = 0; k < 8; k++) progWord(s*8 + k, 32'h1000_0000 + 32'(s*8 + k));
    progWord(s*8 + 0, opt);
    progWord(s*8 + 2, cnt);
    progWord(s*8 + 5, lnk);
    progWord(s*8 + 7, cc);
  endtask

  task automatic drvIssue(input int ch);
    issValid = 1'b1; issChan = CH_W'(ch);
    issOpt = mem[ch*8 + 0]; issCntWord = mem[ch*8 + 2];
    issLinkWord = mem[ch*8 + 5]; issCcntWord = mem[ch*8 + 7];
  endtask

  task automatic issueReq(input int ch);
    drvIssue(ch);
    @(negedge clk);
    issValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic clearBits(input logic [NUM_CHAN-1:0] m);
    intClrValid = 1'b1; intClrMask = m;
    @(negedge clk);
    intClrValid = 1'b0; intClrMask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b, c, w0;
    bit last;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("reset R10 pending", 32'(intPending), 0);
    chkEq("reset R8 chain", 32'(chainTrig), 0);
    chkEq("reset R11 busy", 32'(busy), 0);
    chkEq("reset R12 err", 32'(errPulse), 0);

    // Array-per-request sweep, early mode, code 5, final int, intermediate chain
    progSet(1, mkOpt(0, 0, 1, 5, 1, 0, 0, 1), {16'd3, 16'd4}, {16'd3, 16'd12}, 32'd2);
    for (int k = 0; k < 8; k++) progWord(12*8 + k, 32'hA500_0000 + 32'(k));
    b = 3; c = 2;
    for (int r = 0; r < 6; r++) begin
      last = (b == 1) && (c == 1);
      issueReq(1);
      if (!last) begin
        chkEq("R8 intermediate chain pulse", 32'(chainTrig), 32'h20);
        chkEq("R6 no final int on intermediate", 32'(intPending[5]), 0);
      end else begin
        chkEq("R6 final int", 32'(intPending[5]), 1);
        chkEq("R8 no intermediate chain on final", 32'(chainTrig), 0);
      end
      waitIdle();
      if (!last) begin
        if (b > 1) b--; else begin b = 3; c--; end
        chkEq("R2 count word", mem[8 + 2], {16'(b), 16'd4});
        chkEq("R2 ccnt word", mem[8 + 7], 32'(c));
      end else begin
        for (int k = 0; k < 8; k++)
          chkEq("R4 link copy", mem[8 + k], 32'hA500_0000 + 32'(k));
      end
    end
    clearBits(8'h20);
    chkEq("R10 w1c clears", 32'(intPending), 0);

    // Frame-per-request sweep, normal mode, code 3, both ints, null link
    progSet(2, mkOpt(0, 1, 0, 3, 1, 1, 0, 0), {16'd4, 16'd8}, {16'd0, 16'hFFFF}, 32'd3);
    for (int cc = 3; cc >= 1; cc--) begin
      last = (cc == 1);
      issueReq(2);
      chkEq("R9 normal mode silent at issue", 32'(intPending[3]), 0);
      waitIdle();
      cmplValid = 1'b1; cmplOpt = mkOpt(0, 1, 0, 3, 1, 1, 0, 0); cmplFinal = last;
      @(negedge clk);
      cmplValid = 1'b0;
      chkEq(last ? "R6 final via completion" : "R7 intermediate via completion",
            32'(intPending[3]), 1);
      clearBits(8'h08);
      if (!last) begin
        chkEq("R3 bcnt kept", mem[16 + 2], {16'd4, 16'd8});
        chkEq("R3 ccnt decremented", mem[16 + 7], 32'(cc - 1));
      end else begin
        for (int k = 0; k < 8; k++)
          chkEq("R5 null set", mem[16 + k], (k == 5) ? 32'h0000FFFF : 32'h0);
      end
    end
    w0 = wrCount;
    issueReq(2);
    chkEq("R5 R12 error after null", 32'(errPulse), 1);
    chkEq("R12 not busy", 32'(busy), 0);
    @(negedge clk);
    chkEq("R5 no write after null", 32'(wrCount), 32'(w0));

    // Zero acnt rejected
    progSet(6, mkOpt(0, 1, 1, 6, 1, 0, 1, 0), {16'd2, 16'd0}, {16'd0, 16'hFFFF}, 32'd1);
    w0 = wrCount;
    issueReq(6);
    chkEq("R12 zero acnt error", 32'(errPulse), 1);
    chkEq("R12 zero acnt no chain", 32'(chainTrig), 0);
    @(negedge clk);
    chkEq("R12 zero acnt no write", 32'(wrCount), 32'(w0));

    // Fixed set, final chain to code 6
    progSet(3, mkOpt(1, 1, 1, 6, 0, 0, 1, 0), {16'd1, 16'd1}, {16'd0, 16'd7}, 32'd1);
    w0 = wrCount;
    issueReq(3);
    chkEq("R8 final chain pulse", 32'(chainTrig), 32'h40);
    chkEq("R1 fixed not busy", 32'(busy), 0);
    @(negedge clk);
    chkEq("R8 pulse is one cycle", 32'(chainTrig), 0);
    chkEq("R1 fixed no write", 32'(wrCount), 32'(w0));
    chkEq("R1 fixed ccnt kept", mem[24 + 7], 32'd1);

    // Issue during write-back
    progSet(4, mkOpt(0, 1, 1, 0, 0, 0, 0, 0), {16'd2, 16'd2}, {16'd0, 16'hFFFF}, 32'd2);
    drvIssue(4);
    @(negedge clk);
    chkEq("R11 first accepted", 32'(errPulse), 0);
    chkEq("R11 busy after accept", 32'(busy), 1);
    @(negedge clk);
    issValid = 1'b0;
    chkEq("R11 busy reject", 32'(errPulse), 1);
    waitIdle();
    chkEq("R11 single decrement", mem[32 + 7], 32'd1);

    // Same-cycle: early issue (code 1) + normal completion (code 2) + clear of bit 1
    progSet(5, mkOpt(1, 1, 1, 1, 1, 0, 1, 0), {16'd1, 16'd1}, {16'd0, 16'hFFFF}, 32'd1);
    cmplValid = 1'b1; cmplOpt = mkOpt(0, 0, 0, 2, 1, 0, 1, 0); cmplFinal = 1'b1;
    intClrValid = 1'b1; intClrMask = 8'h02;
    issueReq(5);
    cmplValid = 1'b0; intClrValid = 1'b0; intClrMask = '0;
    chkEq("R10 set wins over clear, both sources", 32'(intPending), 32'h06);
    chkEq("R8 R9 two chain sources", 32'(chainTrig), 32'h06);
    clearBits(8'h04);
    chkEq("R10 clear leaves other bit", 32'(intPending), 32'h02);
    cmplValid = 1'b1; cmplOpt = mkOpt(0, 0, 1, 4, 1, 0, 1, 0); cmplFinal = 1'b1;
    @(negedge clk);
    cmplValid = 1'b0;
    chkEq("R9 early completion ignored pending", 32'(intPending), 32'h02);
    chkEq("R9 early completion ignored chain", 32'(chainTrig), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule